// File: doc/BRIEF.md
# Tiled Address Channel Swizzle Unit

This unit sits in the address path between a tiled-surface client and a dual-channel memory controller. Interleaved memory switches channel every 64 bytes, so bit 6 of a byte address picks the channel. When a surface is tiled, the graphics side spreads accesses across both channels by folding some higher address bits into bit 6. The unit applies that fold, so that addresses coming out of the tiled walk match the channel mapping the memory side expects.

The set of folded bits depends on two things. The first is the surface tiling (linear, X-tiled or Y-tiled). The second is a memory configuration word plus the last rank-boundary values of the two channels, from which the unit derives the active swizzle mode. Each request is registered once. Its result appears one clock later, together with a 3-bit status code that names the swizzle mode applied to that request.

Top module: `tile_swizzle_unit`

## Requirements
- R1: With addressing mode 2 (dual interleaved, `cfg_word[1:0]`) and the XOR-disable flag `cfg_word[2]` set, X tiling (`tile_mode`=1) folds bits 9 and 10 into bit 6 with status 2. Y tiling (`tile_mode`=2) folds bit 9 only, with status 1.
- R2: In mode 2 with `cfg_word[2]` clear and the bit-17 select `cfg_word[3]` clear, X folds bits 9, 10 and 11 (status 4). Y folds bits 9 and 11 (status 3).
- R3: In mode 2 with `cfg_word[2]` clear and `cfg_word[3]` set, X folds bits 9, 10 and 17 (status 6). Y folds bits 9 and 17 (status 5).
- R4: Addressing mode 0 (single channel) and mode 1 (dual asymmetric) give status 0 for both X and Y, with the address unchanged.
- R5: A configuration word of all ones gives status 7 (unknown) for X and Y, and the address passes unchanged, as for an untiled surface.
- R6: Addressing mode 3 (rank compare) uses X→bits 9,10 (status 2) and Y→bit 9 (status 1) when `rank_a` equals `rank_b`. Otherwise it uses status 0 and no fold. Flags `cfg_word[3:2]` have no effect in this mode.
- R7: Linear tiling (`tile_mode`=0) and the spare code 3 always give status 0 and an unchanged address, whatever the configuration.
- R8: The output address differs from the input address in no bit other than bit 6.
- R9: `out_valid` repeats `in_valid` one cycle later. `out_addr` and `out_mode` update only for a valid request and otherwise hold.
- R10: While reset is applied, `out_valid`, `out_addr` and `out_mode` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request valid |
| in_addr | input | ADDR_W | Byte address into the tiled surface |
| tile_mode | input | 2 | 0 linear, 1 X-tiled, 2 Y-tiled, 3 treated as linear |
| cfg_word | input | CFG_W | Memory configuration word: [1:0] addressing mode, [2] XOR disable, [3] bit-17 select |
| rank_a | input | RANK_W | Last rank-boundary value, channel A |
| rank_b | input | RANK_W | Last rank-boundary value, channel B |
| out_valid | output | 1 | Result valid |
| out_addr | output | ADDR_W | Swizzled address |
| out_mode | output | 3 | Applied swizzle: 0 none, 1 b9, 2 b9/10, 3 b9/11, 4 b9/10/11, 5 b9/17, 6 b9/10/17, 7 unknown |

## Verification
Every result is due exactly one rising edge after the request is presented: address, status and valid all come from a single register stage. The bench drives each request on a falling edge and reads the outputs on the following falling edge, so each sample falls between the capturing edge and the next one. A request is presented on every cycle of the sweeps, so each sample also confirms that the previous request's value has been replaced. The hold case drops `in_valid` and samples one cycle later to confirm that the outputs kept the last valid result.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_SPARE  = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_e;

  typedef enum logic [1:0] {
    AM_SINGLE      = 2'd0,
    AM_ASYM        = 2'd1,
    AM_INTERLEAVED = 2'd2,
    AM_RANKCMP     = 2'd3
  } amode_e;

  // field positions inside the configuration word
  localparam int unsigned FLD_AMODE_LSB = 0;
  localparam int unsigned FLD_XOR_DIS   = 2;
  localparam int unsigned FLD_SEL17     = 3;

  // address bit positions taking part in the fold
  localparam int unsigned CHAN_BIT = 6;
  localparam int unsigned FOLD_B9  = 9;
  localparam int unsigned FOLD_B10 = 10;
  localparam int unsigned FOLD_B11 = 11;
  localparam int unsigned FOLD_B17 = 17;

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
#(
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned RANK_W = 16
) (
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [RANK_W-1:0] rank_a,
  input  logic [RANK_W-1:0] rank_b,
  output swz_e              x_mode,
  output swz_e              y_mode
);

  amode_e amode;
  logic   xor_dis;
  logic   sel17;
  logic   cfg_dead;

  always_comb begin
    amode    = amode_e'(cfg_word[FLD_AMODE_LSB +: 2]);
    xor_dis  = cfg_word[FLD_XOR_DIS];
    sel17    = cfg_word[FLD_SEL17];
    cfg_dead = &cfg_word;
  end

  always_comb begin
    x_mode = SWZ_NONE;
    y_mode = SWZ_NONE;
    unique case (amode)
      AM_SINGLE, AM_ASYM: begin
        x_mode = SWZ_NONE;
        y_mode = SWZ_NONE;
      end
      AM_INTERLEAVED: begin
        if (xor_dis) begin
          x_mode = SWZ_9_10;
          y_mode = SWZ_9;
        end else if (!sel17) begin
          x_mode = SWZ_9_10_11;
          y_mode = SWZ_9_11;
        end else begin
          x_mode = SWZ_9_10_17;
          y_mode = SWZ_9_17;
        end
      end
      AM_RANKCMP: begin
        if (rank_a == rank_b) begin
          x_mode = SWZ_9_10;
          y_mode = SWZ_9;
        end
      end
      default: begin
        x_mode = SWZ_NONE;
        y_mode = SWZ_NONE;
      end
    endcase
    if (cfg_dead) begin
      x_mode = SWZ_UNKNOWN;
      y_mode = SWZ_UNKNOWN;
    end
  end

endmodule

// File: rtl/swz_mode_pick.sv
module swz_mode_pick
  import swz_pkg::*;
(
  input  logic [1:0] tile_mode,
  input  swz_e       x_mode,
  input  swz_e       y_mode,
  output swz_e       eff_mode
);

  tile_e tile;

  always_comb begin
    tile = tile_e'(tile_mode);
    unique case (tile)
      TILE_X:  eff_mode = x_mode;
      TILE_Y:  eff_mode = y_mode;
      default: eff_mode = SWZ_NONE;
    endcase
  end

endmodule

// File: rtl/swz_bit6_xor.sv
module swz_bit6_xor
  import swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_e              mode,
  output logic [ADDR_W-1:0] addr_o
);

  logic use9, use10, use11, use17;
  logic fold;

  always_comb begin
    use9  = 1'b0;
    use10 = 1'b0;
    use11 = 1'b0;
    use17 = 1'b0;
    unique case (mode)
      SWZ_9:       begin use9 = 1'b1; end
      SWZ_9_10:    begin use9 = 1'b1; use10 = 1'b1; end
      SWZ_9_11:    begin use9 = 1'b1; use11 = 1'b1; end
      SWZ_9_10_11: begin use9 = 1'b1; use10 = 1'b1; use11 = 1'b1; end
      SWZ_9_17:    begin use9 = 1'b1; use17 = 1'b1; end
      SWZ_9_10_17: begin use9 = 1'b1; use10 = 1'b1; use17 = 1'b1; end
      default:     begin use9 = 1'b0; end
    endcase
  end

  always_comb begin
    fold = addr_i[CHAN_BIT]
         ^ (use9  & addr_i[FOLD_B9])
         ^ (use10 & addr_i[FOLD_B10])
         ^ (use11 & addr_i[FOLD_B11])
         ^ (use17 & addr_i[FOLD_B17]);
  end

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    if (g == CHAN_BIT) begin : g_chan
      assign addr_o[g] = fold;
    end else begin : g_pass
      assign addr_o[g] = addr_i[g];
    end
  end

endmodule

// File: rtl/tile_swizzle_unit.sv
module tile_swizzle_unit
  import swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned RANK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        tile_mode,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [RANK_W-1:0] rank_a,
  input  logic [RANK_W-1:0] rank_b,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_mode
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  swz_e              x_mode;
  swz_e              y_mode;
  swz_e              eff_mode;
  logic [ADDR_W-1:0] swz_addr;

  swz_cfg_decode #(.CFG_W(CFG_W), .RANK_W(RANK_W)) i_decode (
    .cfg_word (cfg_word),
    .rank_a   (rank_a),
    .rank_b   (rank_b),
    .x_mode   (x_mode),
    .y_mode   (y_mode)
  );

  swz_mode_pick i_pick (
    .tile_mode (tile_mode),
    .x_mode    (x_mode),
    .y_mode    (y_mode),
    .eff_mode  (eff_mode)
  );

  swz_bit6_xor #(.ADDR_W(ADDR_W)) i_xor (
    .addr_i (in_addr),
    .mode   (eff_mode),
    .addr_o (swz_addr)
  );

  // next state
  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] addr_d,  addr_q;
  logic [2:0]        mode_d,  mode_q;
  logic              load_en;

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    addr_d  = addr_q;
    mode_d  = mode_q;
    if (load_en) begin
      addr_d = swz_addr;
      mode_d = eff_mode;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      mode_q  <= 3'd0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      mode_q  <= mode_d;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_mode  = mode_q;

endmodule

// File: rtl/tile_swizzle_chk.sv
module tile_swizzle_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned RANK_W = 16
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        tile_mode,
  input logic [CFG_W-1:0]  cfg_word,
  input logic [RANK_W-1:0] rank_a,
  input logic [RANK_W-1:0] rank_b,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [2:0]        out_mode
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << 6);

  logic tiled;
  logic dead;
  assign tiled = (tile_mode == 2'd1) || (tile_mode == 2'd2);
  assign dead  = &cfg_word;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid == $past(in_valid));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(out_addr) && $stable(out_mode)));

  p_only_bit6_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> (((out_addr ^ $past(in_addr)) & KEEP_MASK) == '0));

  p_linear_clean_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !tiled) |=> (out_mode == 3'd0 && out_addr == $past(in_addr)));

  p_dead_cfg_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && tiled && dead) |=> (out_mode == 3'd7 && out_addr == $past(in_addr)));

  p_no_interleave_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !dead && cfg_word[1] == 1'b0) |=> (out_mode == 3'd0));

  p_rank_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !dead && cfg_word[1:0] == 2'd3 && rank_a != rank_b) |=> (out_mode == 3'd0));

endmodule

bind tile_swizzle_unit tile_swizzle_chk #(
  .ADDR_W (ADDR_W),
  .CFG_W  (CFG_W),
  .RANK_W (RANK_W)
) i_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .tile_mode (tile_mode),
  .cfg_word  (cfg_word),
  .rank_a    (rank_a),
  .rank_b    (rank_b),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_mode  (out_mode)
);

// File: tb/test_tile_swizzle_unit.sv
`timescale 1ns/1ps
module test_tile_swizzle_unit;

  localparam int unsigned AW = 32;
  localparam int unsigned CW = 32;
  localparam int unsigned RW = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] in_addr;
  logic [1:0]    tile_mode;
  logic [CW-1:0] cfg_word;
  logic [RW-1:0] rank_a;
  logic [RW-1:0] rank_b;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [2:0]    out_mode;

  int errors;
  int checks;
  logic [31:0] lfsr;

  tile_swizzle_unit #(.ADDR_W(AW), .CFG_W(CW), .RANK_W(RW)) i_tile_swizzle_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .tile_mode (tile_mode),
    .cfg_word  (cfg_word),
    .rank_a    (rank_a),
    .rank_b    (rank_b),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_mode  (out_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // expected status code from the requirement tables
  function automatic int exp_code(input int tile, input logic [CW-1:0] cfg,
                                  input logic [RW-1:0] ra, input logic [RW-1:0] rb);
    int am;
    if (tile != 1 && tile != 2) return 0;
    if (cfg == {CW{1'b1}}) return 7;
    am = int'(cfg[1:0]);
    if (am < 2) return 0;
    if (am == 3) return (ra == rb) ? ((tile == 1) ? 2 : 1) : 0;
    if (cfg[2]) return (tile == 1) ? 2 : 1;
    if (!cfg[3]) return (tile == 1) ? 4 : 3;
    return (tile == 1) ? 6 : 5;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int code);
    int bits [4];
    int n;
    logic p;
    n = 0;
    case (code)
      1: begin bits[0] = 9; n = 1; end
      2: begin bits[0] = 9; bits[1] = 10; n = 2; end
      3: begin bits[0] = 9; bits[1] = 11; n = 2; end
      4: begin bits[0] = 9; bits[1] = 10; bits[2] = 11; n = 3; end
      5: begin bits[0] = 9; bits[1] = 17; n = 2; end
      6: begin bits[0] = 9; bits[1] = 10; bits[2] = 17; n = 3; end
      default: n = 0;
    endcase
    p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ a[bits[i]];
    return a ^ ({{(AW-1){1'b0}}, p} << 6);
  endfunction

  function automatic string req_tag(input int tile, input logic [CW-1:0] cfg);
    if (tile != 1 && tile != 2) return "R7";
    if (cfg == {CW{1'b1}}) return "R5";
    case (cfg[1:0])
      2'd0, 2'd1: return "R4";
      2'd3:       return "R6";
      default: begin
        if (cfg[2]) return "R1";
        if (!cfg[3]) return "R2";
        return "R3";
      end
    endcase
  endfunction

  // present one request on a falling edge; result read one edge later
  task automatic send(input logic [AW-1:0] a, input int tile, input logic [CW-1:0] cfg,
                      input logic [RW-1:0] ra, input logic [RW-1:0] rb);
    int code;
    string tag;
    in_valid  = 1'b1;
    in_addr   = a;
    tile_mode = tile[1:0];
    cfg_word  = cfg;
    rank_a    = ra;
    rank_b    = rb;
    code = exp_code(tile, cfg, ra, rb);
    tag  = req_tag(tile, cfg);
    @(negedge clk);
    check("R9", "out_valid", 64'(out_valid), 64'd1);
    check(tag, "out_mode", 64'(out_mode), 64'(code));
    check(tag, "out_addr", 64'(out_addr), 64'(exp_addr(a, code)));
    check("R8", "addr bits other than 6", 64'((out_addr ^ a) & ~32'h40), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] base;
    logic [AW-1:0] held_addr;
    logic [2:0]    held_mode;
    errors    = 0;
    checks    = 0;
    lfsr      = 32'h1ACE_B00C;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_addr   = '0;
    tile_mode = 2'd0;
    cfg_word  = '0;
    rank_a    = '0;
    rank_b    = '0;

    repeat (3) @(negedge clk);
    // R10: outputs cleared during reset
    check("R10", "out_valid in reset", 64'(out_valid), 64'd0);
    check("R10", "out_addr in reset", 64'(out_addr), 64'd0);
    check("R10", "out_mode in reset", 64'(out_mode), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep: addressing mode x flags x tiling x every fold-bit pattern
    for (int am = 0; am < 4; am++) begin
      for (int fl = 0; fl < 4; fl++) begin
        for (int tile = 0; tile < 4; tile++) begin
          for (int k = 0; k < 32; k++) begin
            logic [CW-1:0] cfg;
            logic [RW-1:0] ra;
            logic [RW-1:0] rb;
            lfsr = next_rand(lfsr);
            base = lfsr;
            base[6]  = k[0];
            base[9]  = k[1];
            base[10] = k[2];
            base[11] = k[3];
            base[17] = k[4];
            cfg = {lfsr[31:8] & 24'h00_7FFF, 4'h0, fl[1:0], am[1:0]};
            ra  = RW'(k * 37 + am);
            rb  = (fl[0]) ? (ra ^ 16'h0100) : ra;   // R6 equal and unequal ranks
            send(base, tile, cfg, ra, rb);
          end
        end
      end
    end

    // R5: unreadable configuration word, every tiling and fold pattern
    for (int tile = 0; tile < 4; tile++) begin
      for (int k = 0; k < 32; k++) begin
        lfsr = next_rand(lfsr);
        base = lfsr;
        base[6]  = k[0];
        base[9]  = k[1];
        base[10] = k[2];
        base[11] = k[3];
        base[17] = k[4];
        send(base, tile, {CW{1'b1}}, 16'h1234, 16'h1234);
      end
    end

    // R9: idle cycle holds the last result while inputs change
    send(32'h0002_0E40, 1, 32'h0000_0002, 16'h0, 16'h0);
    held_addr = out_addr;
    held_mode = out_mode;
    in_valid  = 1'b0;
    in_addr   = 32'hFFFF_FFFF;
    tile_mode = 2'd2;
    cfg_word  = 32'h0000_000A;
    @(negedge clk);
    check("R9", "out_valid after idle", 64'(out_valid), 64'd0);
    check("R9", "out_addr held", 64'(out_addr), 64'(held_addr));
    check("R9", "out_mode held", 64'(out_mode), 64'(held_mode));
    @(negedge clk);
    check("R9", "out_addr still held", 64'(out_addr), 64'(held_addr));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule